// File: doc/BRIEF.md
# Remote DMA Command Engine

This block moves data between a host-facing data port and a byte-addressed packet buffer memory. The host writes a start address and a byte count into the register file, one byte at a time, and then issues a command. A remote read fetches bytes from memory and delivers them on the outbound data channel. A remote write takes data from the inbound channel and stores it in memory. Both channels use a valid/ready handshake.

While a transfer runs, the current address and the remaining count can be read back. When the count reaches zero, the engine sets a completion flag, which can also drive an interrupt. An abort command stops the engine at once. The address and count then keep the values they had reached.

Each beat moves either one byte or a 16-bit pair of bytes. In word mode, a byte-order bit decides which half of the 16-bit host data belongs to the lower memory address.

Top module: `rdma_engine`

## Requirements
- R1: After reset the engine is idle: address, count, configuration and status read as zero, `irq` is low, and no memory access, `rd_valid` or `wr_ready` is asserted.
- R2: Register map on `reg_addr`: 0 and 1 are the address low and high bytes, 2 and 3 are the count low and high bytes (both read back their current values), 4 is the command (write bits [2:0]), 5 is the configuration (bit0 word mode, bit1 big-endian, bit2 interrupt enable), and 6 is the status (bit0 complete, bit1 busy).
- R3: Command 001 (remote read) in byte mode reads the byte at the current address and presents it on `rd_data[7:0]` with the upper byte zero. Each accepted beat raises the address by 1 and lowers the count by 1.
- R4: Command 010 (remote write) in byte mode stores `wr_data[7:0]` at the current address with only strobe bit0 set. Each accepted beat raises the address by 1 and lowers the count by 1.
- R5: In word mode, with two or more bytes left, a beat moves two bytes and steps the address by +2 and the count by -2. Little-endian places the byte at the lower address on host bits [7:0]. Big-endian places it on bits [15:8].
- R6: In word mode with one byte left, the final beat moves a single byte on host bits [7:0] and writes only the lower-address byte.
- R7: While `rd_valid` is high and `rd_ready` is low, `rd_data` stays stable and no further memory access occurs. A write beat reaches memory only in a cycle where `wr_valid` is high.
- R8: The complete bit is set once, in the cycle the count reaches zero, and busy clears at the same time. `irq` equals the complete bit gated by the interrupt enable. Writing 1 to status bit0 clears the complete bit; writing 0 leaves it set.
- R9: Any command with bit2 set aborts. The engine goes idle, the address and count keep their advanced values, the complete bit is not set, and no further beats occur.
- R10: Commands 000 and 011 are ignored. Read or write commands issued while busy are ignored. Writes to the address, count and configuration registers while busy are ignored.
- R11: A read or write started with a count of zero sets the complete bit immediately and makes no memory access.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register offset for reads and writes |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Register read data (combinational) |
| irq | output | 1 | Completion interrupt |
| mem_req | output | 1 | Memory access request |
| mem_we | output | 1 | Memory write enable |
| mem_addr | output | ADDR_W | Byte address of the lower byte |
| mem_wdata | output | 16 | Write data: [7:0] at mem_addr, [15:8] at mem_addr+1 |
| mem_wstrb | output | 2 | Byte strobes matching mem_wdata lanes |
| mem_rdata | input | 16 | Read data, valid the cycle after a read request |
| rd_valid | output | 1 | Outbound data valid |
| rd_ready | input | 1 | Outbound data accepted |
| rd_data | output | 16 | Outbound data |
| wr_valid | input | 1 | Inbound data valid |
| wr_data | input | 16 | Inbound data |
| wr_ready | output | 1 | Engine ready for inbound data |

## Verification
The bench aims at the odd byte left over at the end of a word-mode transfer. A design that handles this wrongly would either move two bytes and overwrite the neighbouring memory byte, or leave the count wrapped below zero and never finish. It also holds `rd_ready` low for many cycles. A faulty engine would then change the data or issue extra memory reads during the stall. An abort in the middle of a transfer checks that the address and count keep their advanced values and that no completion is reported. Illegal codes and zero-length starts check that neither one starts a transfer that never ends.

// File: rtl/rdma_engine.sv
module rdma_engine #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [2:0]        reg_addr,
  input  logic [7:0]        reg_wdata,
  output logic [7:0]        reg_rdata,
  output logic              irq,
  output logic              mem_req,
  output logic              mem_we,
  output logic [ADDR_W-1:0] mem_addr,
  output logic [15:0]       mem_wdata,
  output logic [1:0]        mem_wstrb,
  input  logic [15:0]       mem_rdata,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [15:0]       rd_data,
  input  logic              wr_valid,
  input  logic [15:0]       wr_data,
  output logic              wr_ready
);
  localparam logic [2:0] OFS_ALO = 3'd0, OFS_AHI = 3'd1, OFS_CLO = 3'd2, OFS_CHI = 3'd3;
  localparam logic [2:0] OFS_CMD = 3'd4, OFS_CFG = 3'd5, OFS_STS = 3'd6;

  typedef enum logic [2:0] {S_IDLE, S_RREQ, S_RCAP, S_ROUT, S_WR} state_t;

  state_t            state;
  logic [ADDR_W-1:0] cur_addr;
  logic [CNT_W-1:0]  cur_cnt;
  logic              cfg_word, cfg_be, cfg_irq, done;
  logic [15:0]       hold;

  logic idle, busy, wr_cmd, cmd_abort, cmd_read, cmd_write, clr_done;
  logic pair, last, beat;

  assign idle      = (state == S_IDLE);
  assign busy      = !idle;
  assign wr_cmd    = reg_wr && (reg_addr == OFS_CMD);
  assign cmd_abort = wr_cmd && reg_wdata[2];
  assign cmd_read  = wr_cmd && idle && (reg_wdata[2:0] == 3'b001);
  assign cmd_write = wr_cmd && idle && (reg_wdata[2:0] == 3'b010);
  assign clr_done  = reg_wr && (reg_addr == OFS_STS) && reg_wdata[0];

  assign pair = cfg_word && (cur_cnt > CNT_W'(1));
  assign last = pair ? (cur_cnt == CNT_W'(2)) : (cur_cnt == CNT_W'(1));
  assign beat = ((state == S_ROUT) && rd_ready) || ((state == S_WR) && wr_valid);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= S_IDLE;
      cur_addr <= '0;
      cur_cnt  <= '0;
      cfg_word <= 1'b0;
      cfg_be   <= 1'b0;
      cfg_irq  <= 1'b0;
      done     <= 1'b0;
      hold     <= '0;
    end else begin
      if (clr_done) done <= 1'b0;
      if (idle && reg_wr) begin
        case (reg_addr)
          OFS_ALO: cur_addr <= ADDR_W'({cur_addr[ADDR_W-1:8], reg_wdata});
          OFS_AHI: cur_addr <= ADDR_W'({reg_wdata, cur_addr[7:0]});
          OFS_CLO: cur_cnt  <= CNT_W'({cur_cnt[CNT_W-1:8], reg_wdata});
          OFS_CHI: cur_cnt  <= CNT_W'({reg_wdata, cur_cnt[7:0]});
          OFS_CFG: {cfg_irq, cfg_be, cfg_word} <= reg_wdata[2:0];
          default: ;
        endcase
      end
      if (cmd_abort) begin
        state <= S_IDLE;
      end else begin
        case (state)
          S_IDLE: if (cmd_read || cmd_write) begin
            if (cur_cnt == '0) done <= 1'b1;
            else state <= cmd_read ? S_RREQ : S_WR;
          end
          S_RREQ: state <= S_RCAP;
          S_RCAP: begin
            hold  <= mem_rdata;
            state <= S_ROUT;
          end
          default: ;
        endcase
        if (beat) begin
          cur_addr <= cur_addr + (pair ? ADDR_W'(2) : ADDR_W'(1));
          cur_cnt  <= cur_cnt - (pair ? CNT_W'(2) : CNT_W'(1));
          if (last) begin
            state <= S_IDLE;
            done  <= 1'b1;
          end else if (state == S_ROUT) begin
            state <= S_RREQ;
          end
        end
      end
    end
  end

  assign mem_req   = (state == S_RREQ) || ((state == S_WR) && wr_valid && !cmd_abort);
  assign mem_we    = (state == S_WR);
  assign mem_addr  = cur_addr;
  assign mem_wstrb = pair ? 2'b11 : 2'b01;
  assign mem_wdata = !pair ? {8'h00, wr_data[7:0]} :
                     cfg_be ? {wr_data[7:0], wr_data[15:8]} : wr_data;

  assign rd_valid = (state == S_ROUT);
  assign rd_data  = !pair ? {8'h00, hold[7:0]} :
                    cfg_be ? {hold[7:0], hold[15:8]} : hold;
  assign wr_ready = (state == S_WR);

  assign irq = done && cfg_irq;

  always_comb begin
    case (reg_addr)
      OFS_ALO: reg_rdata = cur_addr[7:0];
      OFS_AHI: reg_rdata = 8'(cur_addr >> 8);
      OFS_CLO: reg_rdata = cur_cnt[7:0];
      OFS_CHI: reg_rdata = 8'(cur_cnt >> 8);
      OFS_CFG: reg_rdata = {5'b0, cfg_irq, cfg_be, cfg_word};
      OFS_STS: reg_rdata = {6'b0, busy, done};
      default: reg_rdata = 8'h00;
    endcase
  end
endmodule

// File: rtl/rdma_engine_chk.sv
module rdma_engine_chk #(
  parameter int ADDR_W = 16,
  parameter int CNT_W  = 16
) (
  input logic              clk,
  input logic              rst_n,
  input logic              reg_wr,
  input logic [2:0]        reg_addr,
  input logic [2:0]        cmd_bits,
  input logic              mem_req,
  input logic              mem_we,
  input logic              rd_valid,
  input logic              rd_ready,
  input logic [15:0]       rd_data,
  input logic              wr_valid,
  input logic              busy,
  input logic              done,
  input logic [ADDR_W-1:0] cur_addr,
  input logic [CNT_W-1:0]  cur_cnt
);
  logic abort_now;
  assign abort_now = reg_wr && (reg_addr == 3'd4) && cmd_bits[2];

  AST_RD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid && !rd_ready && !abort_now |=> rd_valid && $stable(rd_data) && !mem_req); // R7
  AST_WR_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req && mem_we |-> wr_valid); // R4
  AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> cur_cnt == '0 && !busy); // R8
  AST_ABORT_FREEZE: assert property (@(posedge clk) disable iff (!rst_n)
    abort_now |=> !busy && $stable(cur_addr) && $stable(cur_cnt)); // R9
  AST_ILLEGAL_IGNORED: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 3'd4 && !busy && (cmd_bits == 3'b000 || cmd_bits == 3'b011) |=> !busy); // R10
  AST_DONE_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr && reg_addr == 3'd6 && cmd_bits[0] && !busy |=> !done); // R8
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> !mem_req && !rd_valid); // R11
endmodule

bind rdma_engine rdma_engine_chk #(.ADDR_W(ADDR_W), .CNT_W(CNT_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
  .cmd_bits(reg_wdata[2:0]), .mem_req(mem_req), .mem_we(mem_we),
  .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
  .wr_valid(wr_valid), .busy(busy), .done(done),
  .cur_addr(cur_addr), .cur_cnt(cur_cnt)
);

// File: tb/rdma_engine_bench.sv
`timescale 1ns/1ps
module rdma_engine_bench;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [2:0]  reg_addr = 3'd0;
  logic [7:0]  reg_wdata = 8'd0;
  logic [7:0]  reg_rdata;
  logic        irq, mem_req, mem_we;
  logic [15:0] mem_addr, mem_wdata, mem_rdata;
  logic [1:0]  mem_wstrb;
  logic        rd_valid, wr_ready;
  logic        rd_ready = 1'b0;
  logic [15:0] rd_data;
  logic        wr_valid = 1'b0;
  logic [15:0] wr_data = 16'd0;

  int checks = 0, fails = 0, mem_acc = 0;
  logic [7:0] mem [0:255];

  always #5 clk = ~clk;

  rdma_engine u_rdma_engine (
    .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq(irq),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_wstrb(mem_wstrb), .mem_rdata(mem_rdata),
    .rd_valid(rd_valid), .rd_ready(rd_ready), .rd_data(rd_data),
    .wr_valid(wr_valid), .wr_data(wr_data), .wr_ready(wr_ready)
  );

  function automatic logic [7:0] pat(input int i);
    return 8'(i * 7 + 3);
  endfunction

  always @(posedge clk) begin
    if (!rst_n) begin
      for (int i = 0; i < 256; i++) mem[i] <= pat(i);
      mem_rdata <= 16'h0;
    end else if (mem_req) begin
      mem_acc = mem_acc + 1;
      if (mem_we) begin
        if (mem_wstrb[0]) mem[mem_addr[7:0]] <= mem_wdata[7:0];
        if (mem_wstrb[1]) mem[mem_addr[7:0] + 8'd1] <= mem_wdata[15:8];
      end else begin
        mem_rdata <= {mem[mem_addr[7:0] + 8'd1], mem[mem_addr[7:0]]};
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic wreg(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rreg(input logic [2:0] a, output logic [7:0] d);
    @(negedge clk);
    reg_addr = a;
    #1 d = reg_rdata;
  endtask

  task automatic setup(input logic [15:0] a, input logic [15:0] n, input logic [7:0] cfg);
    wreg(3'd0, a[7:0]); wreg(3'd1, a[15:8]);
    wreg(3'd2, n[7:0]); wreg(3'd3, n[15:8]);
    wreg(3'd5, cfg);
  endtask

  task automatic get_beat(output logic [15:0] d);
    @(negedge clk);
    rd_ready = 1'b1;
    while (!rd_valid) @(negedge clk);
    d = rd_data;
    @(negedge clk);
    rd_ready = 1'b0;
  endtask

  task automatic put_beat(input logic [15:0] d);
    @(negedge clk);
    wr_valid = 1'b1; wr_data = d;
    while (!wr_ready) @(negedge clk);
    @(negedge clk);
    wr_valid = 1'b0;
  endtask

  task automatic t_reset;
    logic [7:0] v;
    rreg(3'd0, v); chk("R1 addr lo", v, 0);
    rreg(3'd2, v); chk("R1 count lo", v, 0);
    rreg(3'd5, v); chk("R1 config", v, 0);
    rreg(3'd6, v); chk("R1 status", v, 0);
    chk("R1 irq/req/valid/ready", {irq, mem_req, rd_valid, wr_ready}, 0);
  endtask

  task automatic t_byte_read;
    logic [15:0] d; logic [7:0] v;
    setup(16'h0010, 16'd3, 8'h04);
    wreg(3'd4, 8'h01);
    rreg(3'd6, v); chk("R2 busy during read", v[1], 1);
    for (int i = 0; i < 3; i++) begin
      get_beat(d); chk("R3 byte read data", d, {8'h00, pat(16 + i)});
    end
    rreg(3'd0, v); chk("R3 address advanced", v, 8'h13);
    rreg(3'd2, v); chk("R3 count at zero", v, 0);
    rreg(3'd6, v); chk("R8 complete set, busy clear", v, 8'h01);
    chk("R8 irq with enable", irq, 1);
    wreg(3'd6, 8'h00);
    rreg(3'd6, v); chk("R8 write zero keeps complete", v, 8'h01);
    wreg(3'd6, 8'h01);
    rreg(3'd6, v); chk("R8 write one clears complete", v, 8'h00);
    chk("R8 irq cleared", irq, 0);
  endtask

  task automatic t_byte_write;
    logic [7:0] v;
    setup(16'h0040, 16'd2, 8'h00);
    wreg(3'd4, 8'h02);
    put_beat(16'h77A1);
    put_beat(16'h66B2);
    chk("R4 byte write 0", mem[8'h40], 8'hA1);
    chk("R4 byte write 1", mem[8'h41], 8'hB2);
    chk("R4 neighbour untouched", mem[8'h42], pat(8'h42));
    rreg(3'd6, v); chk("R8 complete after write", v, 8'h01);
    chk("R8 irq masked", irq, 0);
    wreg(3'd6, 8'h01);
  endtask

  task automatic t_word_read;
    logic [15:0] d; logic [7:0] v;
    setup(16'h0020, 16'd3, 8'h01);
    wreg(3'd4, 8'h01);
    get_beat(d); chk("R5 little-endian word", d, {pat(8'h21), pat(8'h20)});
    get_beat(d); chk("R6 residual byte read", d, {8'h00, pat(8'h22)});
    rreg(3'd0, v); chk("R5 address step", v, 8'h23);
    rreg(3'd6, v); chk("R6 completes after residual", v, 8'h01);
    wreg(3'd6, 8'h01);
    setup(16'h0020, 16'd2, 8'h03);
    wreg(3'd4, 8'h01);
    get_beat(d); chk("R5 big-endian word", d, {pat(8'h20), pat(8'h21)});
    rreg(3'd6, v); chk("R5 complete after one word", v, 8'h01);
    wreg(3'd6, 8'h01);
  endtask

  task automatic t_word_write;
    setup(16'h0060, 16'd2, 8'h03);
    wreg(3'd4, 8'h02);
    put_beat(16'h1234);
    chk("R5 big-endian low addr", mem[8'h60], 8'h12);
    chk("R5 big-endian high addr", mem[8'h61], 8'h34);
    wreg(3'd6, 8'h01);
    setup(16'h0070, 16'd3, 8'h01);
    wreg(3'd4, 8'h02);
    put_beat(16'hBEEF);
    put_beat(16'h55C3);
    chk("R5 little-endian word", {mem[8'h71], mem[8'h70]}, 16'hBEEF);
    chk("R6 residual byte", mem[8'h72], 8'hC3);
    chk("R6 byte after residual untouched", mem[8'h73], pat(8'h73));
    wreg(3'd6, 8'h01);
  endtask

  task automatic t_stall;
    logic [15:0] d, first; int acc0;
    setup(16'h0030, 16'd2, 8'h00);
    wreg(3'd4, 8'h01);
    repeat (6) @(negedge clk);
    chk("R7 valid while stalled", rd_valid, 1);
    first = rd_data; acc0 = mem_acc;
    chk("R7 stalled data", first, {8'h00, pat(8'h30)});
    repeat (5) @(negedge clk);
    chk("R7 data stable", rd_data, first);
    chk("R7 no memory access while stalled", mem_acc, acc0);
    get_beat(d); chk("R7 first beat after stall", d, first);
    get_beat(d); chk("R7 second beat", d, {8'h00, pat(8'h31)});
    wreg(3'd6, 8'h01);
  endtask

  task automatic t_abort;
    logic [15:0] d; logic [7:0] v; int acc0;
    setup(16'h0010, 16'd4, 8'h00);
    wreg(3'd4, 8'h01);
    get_beat(d); get_beat(d);
    wreg(3'd4, 8'h04);
    acc0 = mem_acc;
    repeat (4) @(negedge clk);
    chk("R9 no beats after abort", {rd_valid, wr_ready}, 0);
    chk("R9 no memory after abort", mem_acc, acc0);
    rreg(3'd0, v); chk("R9 address kept advanced", v, 8'h12);
    rreg(3'd2, v); chk("R9 count kept", v, 8'h02);
    rreg(3'd6, v); chk("R9 idle, no complete", v, 8'h00);
  endtask

  task automatic t_ignored;
    logic [7:0] v; int acc0;
    setup(16'h0050, 16'd5, 8'h00);
    acc0 = mem_acc;
    wreg(3'd4, 8'h00);
    rreg(3'd6, v); chk("R10 code 000 ignored", v, 8'h00);
    wreg(3'd4, 8'h03);
    rreg(3'd6, v); chk("R10 code 011 ignored", v, 8'h00);
    chk("R10 no memory access", mem_acc, acc0);
    wreg(3'd4, 8'h02);
    wreg(3'd0, 8'h99);
    rreg(3'd0, v); chk("R10 address write while busy ignored", v, 8'h50);
    wreg(3'd5, 8'h07);
    rreg(3'd5, v); chk("R10 config write while busy ignored", v, 8'h00);
    wreg(3'd4, 8'h01);
    @(negedge clk);
    chk("R10 read while busy ignored", {wr_ready, rd_valid}, 2'b10);
    wreg(3'd4, 8'h07);
    rreg(3'd6, v); chk("R9 abort code 111", v, 8'h00);
  endtask

  task automatic t_zero;
    logic [7:0] v; int acc0;
    setup(16'h0080, 16'd0, 8'h00);
    acc0 = mem_acc;
    wreg(3'd4, 8'h01);
    rreg(3'd6, v); chk("R11 zero count completes", v, 8'h01);
    chk("R11 no memory access", mem_acc, acc0);
    wreg(3'd6, 8'h01);
    wreg(3'd4, 8'h02);
    rreg(3'd6, v); chk("R11 zero-count write completes", v, 8'h01);
    wreg(3'd6, 8'h01);
  endtask

  bit finished = 0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      fails++;
      $display("FAIL watchdog: actual=hung expected=finish");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (2) @(negedge clk);
    t_reset;
    t_byte_read;
    t_byte_write;
    t_word_read;
    t_word_write;
    t_stall;
    t_abort;
    t_ignored;
    t_zero;
    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule